// File: doc/BRIEF.md
# Interface Clock Loss Watchdog

This block watches an external interface clock from a free-running reference clock. If that clock stops, the block holds the logic in the interface domain in reset until the clock returns. Inside the monitored domain a single register inverts on every monitored edge, so that while the clock runs this heartbeat never holds still. The reference domain brings the heartbeat in through a two-flop synchronizer and compares each synchronized sample with the one before. Any difference clears a saturating silence counter. When the counter reaches its ceiling, the block declares the clock lost.

The lost flag and the system reset together form one active-low reset for the monitored domain. That reset enters the monitored domain through a two-stage chain. It asserts at once, without needing a monitored edge, and it releases only on monitored edges, so the interface logic leaves reset in step with its own recovered clock.

Top module: `clk_loss_watchdog`

## Requirements
- R1: While the monitored clock runs at less than half the reference frequency, the heartbeat changes often enough that `clk_lost` stays 0 and `mon_rst_n` stays 1.
- R2: Once the monitored clock stops, `clk_lost` rises after the silence counter reaches its ceiling of 2^TIMEOUT_W-1 reference cycles (TIMEOUT_W is 16 by default). This happens between MAX-2 and MAX+6 reference cycles after the last monitored edge, where MAX = 2^TIMEOUT_W-1.
- R3: Every heartbeat change seen at the synchronizer output clears the counter to zero, so two pauses that are each shorter than the limit never raise `clk_lost`, whatever their total length.
- R4: The counter holds at MAX and does not wrap, so `clk_lost` stays 1 for as long as the monitored clock stays absent.
- R5: `mon_rst_n` goes low whenever `ref_rst` or `clk_lost` is 1, including while the monitored clock is stopped. It returns high only after two rising edges of `mon_clk`.
- R6: After the clock returns, `clk_lost` falls on the first observed heartbeat change. At that moment `mon_rst_n` is still 0, and it is 1 after two further `mon_clk` rising edges.
- R7: A synchronous, active-high `ref_rst` clears the counter and `clk_lost` and drives `mon_rst_n` low. If the clock is still absent when `ref_rst` is released, `clk_lost` rises again between MAX and MAX+2 reference cycles after the release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Free-running reference clock |
| ref_rst | input | 1 | System reset, active high, synchronous to ref_clk |
| mon_clk | input | 1 | Interface clock under watch |
| clk_lost | output | 1 | High while the monitored clock is judged absent (ref_clk domain) |
| mon_rst_n | output | 1 | Active-low reset for the monitored domain, released on mon_clk |

## Verification
The hardest case to reach is a system reset that arrives while the monitored clock is already gone. The design must then release the lost flag, keep the interface domain in reset without any edge of its own, and raise the flag again after a complete fresh timeout. The bench gets there by gating the monitored clock off, waiting for the flag, pulsing the reset, and then counting reference cycles to the flag's return. The monitored-domain reset is sampled throughout. To keep runs short, the bench narrows the counter through its width parameter.

// File: rtl/cwd_pkg.sv
package cwd_pkg;

    localparam int DEF_TIMEOUT_W  = 16;
    localparam int DEF_SYNC_DEPTH = 2;

    // Flag pair produced by the silence timer for the reset combiner.
    typedef struct packed {
        logic lost_now;   // registered flag
        logic lost_next;  // value the flag takes at the coming edge
    } loss_state_t;

    function automatic logic [31:0] ceiling_of(input int width);
        logic [31:0] v;
        v = '0;
        for (int i = 0; i < width; i++) v[i] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/cwd_heartbeat.sv
module cwd_heartbeat (
    input  logic clk,
    output logic beat
);
    // Free-running: it must keep toggling while its own domain is held
    // in reset, or recovery could never be observed.
    logic beat_q = 1'b0;

    always_ff @(posedge clk) begin
        beat_q <= ~beat_q;
    end

    assign beat = beat_q;
endmodule

// File: rtl/cwd_bit_sync.sv
module cwd_bit_sync #(
    parameter int DEPTH = cwd_pkg::DEF_SYNC_DEPTH
) (
    input  logic clk,
    input  logic d,
    output logic q
);
    logic [DEPTH-1:0] chain = '0;

    generate
        if (DEPTH == 1) begin : g_one
            always_ff @(posedge clk) chain <= d;
        end else begin : g_many
            always_ff @(posedge clk) chain <= {chain[DEPTH-2:0], d};
        end
    endgenerate

    assign q = chain[DEPTH-1];
endmodule

// File: rtl/cwd_silence_timer.sv
module cwd_silence_timer #(
    parameter int TIMEOUT_W = cwd_pkg::DEF_TIMEOUT_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  beat_s,
    output cwd_pkg::loss_state_t  state
);
    import cwd_pkg::*;

    localparam logic [TIMEOUT_W-1:0] CEIL = TIMEOUT_W'(ceiling_of(TIMEOUT_W));

    logic                 beat_prev = 1'b0;
    logic [TIMEOUT_W-1:0] cnt;
    logic [TIMEOUT_W-1:0] cnt_nxt;
    logic                 lost;
    logic                 moved;

    assign moved = beat_s ^ beat_prev;

    always_comb begin
        if (moved)             cnt_nxt = '0;
        else if (cnt == CEIL)  cnt_nxt = cnt;
        else                   cnt_nxt = cnt + 1'b1;
    end

    // The edge detector keeps loading during reset so that no false
    // change appears when reset is released.
    always_ff @(posedge clk) begin
        beat_prev <= beat_s;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            lost <= 1'b0;
        end else begin
            cnt  <= cnt_nxt;
            lost <= (cnt_nxt == CEIL);
        end
    end

    assign state.lost_now  = lost;
    assign state.lost_next = !rst && (cnt_nxt == CEIL);

    AST_CHANGE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        moved |=> (cnt == '0)) else $error("counter not cleared");           // R3

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (cnt == CEIL && !beat_s && !beat_prev) |=> (cnt == CEIL))
        else $error("counter wrapped");                                      // R4

    AST_TOGGLE_RECOVERS: assert property (@(posedge clk) disable iff (rst)
        (lost && moved) |=> !lost) else $error("flag held after toggle");    // R6
endmodule

// File: rtl/cwd_reset_sync.sv
module cwd_reset_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic rst_n
);
    logic [STAGES-1:0] sh = '0;

    // Assertion must not wait for a clock that may be gone; release
    // walks through the chain on the recovered clock.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sh <= '0;
        else         sh <= {sh[STAGES-2:0], 1'b1};
    end

    assign rst_n = sh[STAGES-1];

    AST_RELEASE_LATE: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(rst_n) |-> $past(sh[0])) else $error("early release");        // R5
endmodule

// File: rtl/clk_loss_watchdog.sv
module clk_loss_watchdog #(
    parameter int TIMEOUT_W  = cwd_pkg::DEF_TIMEOUT_W,
    parameter int SYNC_DEPTH = cwd_pkg::DEF_SYNC_DEPTH
) (
    input  logic ref_clk,
    input  logic ref_rst,
    input  logic mon_clk,
    output logic clk_lost,
    output logic mon_rst_n
);
    import cwd_pkg::*;

    localparam int RST_STAGES = 2;

    logic        beat;
    logic        beat_s;
    loss_state_t ls;
    logic        eff_rst_n = 1'b0;

    cwd_heartbeat hb_i (
        .clk  (mon_clk),
        .beat (beat)
    );

    cwd_bit_sync #(.DEPTH(SYNC_DEPTH)) sync_i (
        .clk (ref_clk),
        .d   (beat),
        .q   (beat_s)
    );

    cwd_silence_timer #(.TIMEOUT_W(TIMEOUT_W)) timer_i (
        .clk    (ref_clk),
        .rst    (ref_rst),
        .beat_s (beat_s),
        .state  (ls)
    );

    // Registered so the reset driven into the other domain never glitches.
    always_ff @(posedge ref_clk) begin
        eff_rst_n <= !(ref_rst || ls.lost_next);
    end

    cwd_reset_sync #(.STAGES(RST_STAGES)) rsync_i (
        .clk    (mon_clk),
        .arst_n (eff_rst_n),
        .rst_n  (mon_rst_n)
    );

    assign clk_lost = ls.lost_now;

    AST_LOST_HOLDS_RESET: assert property (@(posedge ref_clk) disable iff (ref_rst)
        clk_lost |-> !mon_rst_n) else $error("domain out of reset while lost"); // R5
endmodule

// File: tb/clk_loss_watchdog_tb_top.sv
`timescale 1ns/1ps
module clk_loss_watchdog_tb_top;
    localparam int W   = 8;
    localparam int MAX = (1 << W) - 1;

    logic ref_clk = 1'b0;
    logic mon_clk = 1'b0;
    logic ref_rst = 1'b1;
    logic mon_run = 1'b1;
    logic clk_lost;
    logic mon_rst_n;

    int n_tests = 0;
    int n_fail  = 0;

    typedef struct {
        logic  lost;
        logic  rstn;
        string tag;
    } exp_t;
    exp_t sb_q[$];

    always #2.5 ref_clk = ~ref_clk;
    always begin
        #8.5;
        if (mon_run) mon_clk = ~mon_clk;
    end

    clk_loss_watchdog #(.TIMEOUT_W(W)) dut_i (
        .ref_clk   (ref_clk),
        .ref_rst   (ref_rst),
        .mon_clk   (mon_clk),
        .clk_lost  (clk_lost),
        .mon_rst_n (mon_rst_n)
    );

    // Monitor: compares one queued expectation per falling reference edge.
    always @(negedge ref_clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_tests++;
            if (clk_lost !== e.lost || mon_rst_n !== e.rstn) begin
                n_fail++;
                $display("FAIL %s: lost=%0b rst_n=%0b expected lost=%0b rst_n=%0b",
                         e.tag, clk_lost, mon_rst_n, e.lost, e.rstn);
            end
        end
    end

    task automatic push_exp(input logic l, input logic r, input string tag);
        exp_t e;
        e.lost = l; e.rstn = r; e.tag = tag;
        sb_q.push_back(e);
        @(negedge ref_clk); #0.1;
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic watch(input int n, output bit seen_lost, output bit seen_low);
        seen_lost = 0; seen_low = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge ref_clk);
            if (clk_lost)   seen_lost = 1;
            if (!mon_rst_n) seen_low  = 1;
        end
    endtask

    task automatic cycles_to_lost(output int n);
        n = 0;
        while (!clk_lost && n < 4 * MAX) begin
            @(negedge ref_clk);
            n++;
        end
    endtask

    initial begin : wd
        repeat (200000) @(posedge ref_clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : drv
        bit sl, slo;
        int n;

        repeat (4) @(posedge ref_clk);
        push_exp(1'b0, 1'b0, "R7 reset state");
        @(negedge ref_clk); ref_rst = 1'b0;
        repeat (20) @(posedge ref_clk);
        push_exp(1'b0, 1'b1, "R5 release with clock running");

        watch(2000, sl, slo);
        check(!sl && !slo, "R1 running clock stays healthy", sl | slo, 0);

        // two sub-limit pauses back to back
        @(negedge ref_clk); mon_run = 0;
        watch(150, sl, slo);
        mon_run = 1;
        watch(40, sl, slo);
        mon_run = 0;
        begin
            bit sl2, slo2;
            watch(150, sl2, slo2);
            sl = sl | sl2;
        end
        mon_run = 1;
        watch(40, sl, slo);
        check(!sl, "R3 separate pauses do not accumulate", sl, 0);
        push_exp(1'b0, 1'b1, "R3 domain still out of reset");

        // clock loss
        @(negedge ref_clk); mon_run = 0;
        cycles_to_lost(n);
        check(n >= MAX - 2 && n <= MAX + 6, "R2 timeout length", n, MAX);
        check(mon_rst_n === 1'b0, "R5 reset asserted without clock", mon_rst_n, 0);

        watch(3 * (MAX + 1), sl, slo);
        push_exp(1'b1, 1'b0, "R4 flag held after long absence");
        begin
            int drops = 0;
            for (int i = 0; i < MAX + 1; i++) begin
                @(negedge ref_clk);
                if (!clk_lost) drops++;
            end
            check(drops == 0, "R4 no wrap of counter", drops, 0);
        end

        // recovery
        mon_run = 1;
        n = 0;
        while (clk_lost && n < 50) begin
            @(negedge ref_clk);
            n++;
        end
        check(n <= 12, "R6 flag clears on first toggle", n, 12);
        check(mon_rst_n === 1'b0, "R6 reset still low at flag clear", mon_rst_n, 0);
        @(posedge mon_clk); @(posedge mon_clk); #1;
        check(mon_rst_n === 1'b1, "R6 release after two monitored edges", mon_rst_n, 1);

        // system reset during loss
        @(negedge ref_clk); mon_run = 0;
        cycles_to_lost(n);
        check(clk_lost === 1'b1, "R2 second loss detected", clk_lost, 1);
        ref_rst = 1'b1;
        repeat (3) @(posedge ref_clk);
        push_exp(1'b0, 1'b0, "R7 reset clears flag during loss");
        ref_rst = 1'b0;
        begin
            int lows = 0;
            n = 0;
            while (!clk_lost && n < 4 * MAX) begin
                @(negedge ref_clk);
                n++;
                if (!mon_rst_n) lows++;
            end
            check(n >= MAX && n <= MAX + 2, "R7 full timeout after reset", n, MAX);
            check(lows == n, "R7 domain held in reset throughout", lows, n);
        end

        mon_run = 1;
        repeat (40) @(posedge ref_clk);
        push_exp(1'b0, 1'b1, "R1 final recovery");

        repeat (4) @(posedge ref_clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule